// File: doc/BRIEF.md
# SMBus Host Command Register Sequencer

This block is the software-facing front end of an SMBus host. Software programs a command byte, a target address with its direction bit and two data bytes through byte-wide register writes. It then writes the control register with the start bit set. The block turns that into one request on an abstract bus-operation port, which carries the protocol, the 7-bit target, the direction, the command byte and a 16-bit write value. The bus engine behind the port handles all pin timing. It answers with a one-cycle completion pulse, an error flag and up to 16 bits of read data.

The completion is folded back into the status register: a completion flag on success, a device-fault flag on error, or a killed flag when software aborts. Read data is loaded into the data registers. A level interrupt follows the non-busy status bits whenever interrupts are enabled. Status bits are cleared by writing ones. The busy bit follows the sequencer alone, and no software write can clear it.

Top module: `smbh_host_seq`

## Requirements
- R1: After reset, every register offset reads 0x00, `irq` is low and `op_valid` is low.
- R2: Offsets 0x3 (command), 0x4 (address), 0x5 (data low) and 0x6 (data high) read back the last byte written. A read of offset 0x2 (control) returns only bits 4:0 of the last write, which are interrupt enable (bit 0), kill (bit 1) and protocol (bits 4:2). Any other offset reads 0x00.
- R3: A control write with bit 6 (start) set, bit 1 clear, protocol 0..4 (quick, byte, byte-data, word-data, process call), no device fault pending and the block idle raises `op_valid` one cycle later. The request carries `op_proto` from control bits 4:2, `op_addr` from address bits 7:1, `op_read` from address bit 0, `op_cmd` from the command byte, and `op_wdata` as {data high, data low}. These values hold steady until `op_ready`.
- R4: Status bit 0 (busy) reads 1 from the request until the completion or a kill.
- R5: When the completion pulse arrives without error, busy clears and status bit 1 (done) is set in the same cycle. Data is loaded only for certain transfers. A byte or byte-data read loads data low from `op_rdata[7:0]`. A word-data read, and a process call of either direction, load data low from `op_rdata[7:0]` and data high from `op_rdata[15:8]`. All other transfers leave the data registers unchanged.
- R6: A completion with `op_err` set sets status bit 2 (device fault), clears busy and loads no data.
- R7: While status bit 2 is set, a start issues no request and busy stays 0.
- R8: A start with protocol 5, 6 or 7 issues no request and sets status bit 2.
- R9: Writing status clears each of bits 7:1 that is written as 1. Bit 0 (busy) is unaffected, and a flag set in the same cycle is kept.
- R10: A control write with bit 1 (kill) set has three effects. It sets status bit 4 (failed) and clears busy. It withdraws any pending request, so a later completion pulse is ignored. A start in the same write is not honoured.
- R11: `irq` is high exactly when control bit 0 is 1 and any of status bits 7:1 is 1. Busy alone never raises it.
- R12: A start written while busy issues no second request and leaves the outstanding request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt level |
| op_valid | output | 1 | Bus-operation request valid |
| op_ready | input | 1 | Bus engine accepts the request |
| op_proto | output | 3 | Protocol code of the request |
| op_addr | output | 7 | Target address |
| op_read | output | 1 | 1 = read direction |
| op_cmd | output | 8 | Command byte |
| op_wdata | output | 16 | Write value {data high, data low} |
| op_done | input | 1 | One-cycle completion pulse |
| op_err | input | 1 | Completion failed or was not acknowledged |
| op_rdata | input | 16 | Read data returned with the completion |

## Verification
A register write takes effect at the clock edge that samples it. The register value, the status bits, `irq` and `op_valid` therefore all show the new state from the following falling edge. The bench drives every input on a falling edge and samples one falling edge after each write or completion pulse. It reads status and data through the combinational read port at that point, so no reading straddles an active edge. The request fields are checked in the first cycle `op_valid` is high. The handshake completes at the edge where `op_ready` is sampled high, and `op_valid` is checked low on the next falling edge.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned PROTO_W = 3;
   localparam int unsigned NBYTE   = 4;             // command, address, data low, data high
   localparam int unsigned WORD_W  = 2 * BYTE_W;
   localparam int unsigned MIN_ADDR_W = 4;

   // register offsets
   localparam int unsigned OFS_STAT = 0;
   localparam int unsigned OFS_CTL  = 2;
   localparam int unsigned OFS_CMD  = 3;
   localparam int unsigned OFS_ADR  = 4;
   localparam int unsigned OFS_DLO  = 5;
   localparam int unsigned OFS_DHI  = 6;

   // control bit positions
   localparam int unsigned CB_IEN   = 0;
   localparam int unsigned CB_KILL  = 1;
   localparam int unsigned CB_START = 6;
   localparam int unsigned CTL_KEEP = 5;            // bits 4:0 are stored

   // protocol codes
   localparam logic [PROTO_W-1:0] PR_QUICK = 3'd0;
   localparam logic [PROTO_W-1:0] PR_BYTE  = 3'd1;
   localparam logic [PROTO_W-1:0] PR_BDAT  = 3'd2;
   localparam logic [PROTO_W-1:0] PR_WDAT  = 3'd3;
   localparam logic [PROTO_W-1:0] PR_PCALL = 3'd4;

   typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_state_e;

   function automatic logic proto_ok(input logic [PROTO_W-1:0] p);
      return p <= PR_PCALL;
   endfunction
endpackage

// File: rtl/smbh_regs.sv
module smbh_regs
   import smbh_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NBYTE-1:0]          wr_byte,
   input  logic                      wr_ctl,
   input  logic [BYTE_W-1:0]         wdata,
   input  logic                      ld_lo,
   input  logic                      ld_hi,
   input  logic [WORD_W-1:0]         ld_val,
   output logic [NBYTE*BYTE_W-1:0]   bytes_q,
   output logic [CTL_KEEP-1:0]       ctl_q
);
   logic [NBYTE-1:0]        ld_vec;
   logic [NBYTE*BYTE_W-1:0] ld_bus;

   // slots 2/3 are data low/high and take bus read data
   assign ld_vec = {ld_hi, ld_lo, 2'b00};
   assign ld_bus = {ld_val, {WORD_W{1'b0}}};

   for (genvar i = 0; i < NBYTE; i++) begin : g_byte
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)          q <= '0;
         else if (ld_vec[i])  q <= ld_bus[i*BYTE_W +: BYTE_W];
         else if (wr_byte[i]) q <= wdata;
      end
      assign bytes_q[i*BYTE_W +: BYTE_W] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (wr_ctl) ctl_q <= wdata[CTL_KEEP-1:0];
   end
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
   import smbh_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                kill,
   input  logic                dev_err,
   input  logic [PROTO_W-1:0]  proto_in,
   input  logic [BYTE_W-1:0]   adr_in,
   input  logic [BYTE_W-1:0]   cmd_in,
   input  logic [WORD_W-1:0]   wd_in,
   output logic                op_valid,
   input  logic                op_ready,
   output logic [PROTO_W-1:0]  op_proto,
   output logic [6:0]          op_addr,
   output logic                op_read,
   output logic [BYTE_W-1:0]   op_cmd,
   output logic [WORD_W-1:0]   op_wdata,
   input  logic                op_done,
   input  logic                op_err,
   output logic                busy,
   output logic                set_done,
   output logic                set_fault,
   output logic                ld_lo,
   output logic                ld_hi
);
   seq_state_e          st_q;
   logic [PROTO_W-1:0]  pr_q;
   logic [BYTE_W-1:0]   adr_q, cmd_q;
   logic [WORD_W-1:0]   wd_q;
   logic                go, finish_ok, rd_byte, rd_word;

   assign go = (st_q == SQ_IDLE) && start && !kill && !dev_err && proto_ok(proto_in);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         pr_q  <= '0;
         adr_q <= '0;
         cmd_q <= '0;
         wd_q  <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (go) begin
               st_q  <= SQ_REQ;
               pr_q  <= proto_in;
               adr_q <= adr_in;
               cmd_q <= cmd_in;
               wd_q  <= wd_in;
            end
            SQ_REQ:  if (kill) st_q <= SQ_IDLE;
                     else if (op_ready) st_q <= SQ_WAIT;
            SQ_WAIT: if (kill || op_done) st_q <= SQ_IDLE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy     = (st_q != SQ_IDLE);
   assign op_valid = (st_q == SQ_REQ);
   assign op_proto = pr_q;
   assign op_addr  = adr_q[7:1];
   assign op_read  = adr_q[0];
   assign op_cmd   = cmd_q;
   assign op_wdata = wd_q;

   assign finish_ok = (st_q == SQ_WAIT) && !kill && op_done;
   assign rd_word   = (pr_q == PR_PCALL) || (adr_q[0] && pr_q == PR_WDAT);
   assign rd_byte   = adr_q[0] && (pr_q == PR_BYTE || pr_q == PR_BDAT);

   assign set_done  = finish_ok && !op_err;
   assign set_fault = (finish_ok && op_err) ||
                      ((st_q == SQ_IDLE) && start && !kill && !proto_ok(proto_in));
   assign ld_lo     = set_done && (rd_byte || rd_word);
   assign ld_hi     = set_done && rd_word;

   AST_NO_REQ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && dev_err && !busy) |=> !op_valid);                             // R7
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_ready && !kill) |=> (op_valid && $stable(op_addr) && $stable(op_proto) && $stable(op_wdata))); // R3
   AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(op_done || kill));                                // R4
   AST_KILL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !busy);                                                        // R10
endmodule

// File: rtl/smbh_status.sv
module smbh_status
   import smbh_pkg::*;
#(
   parameter int unsigned IRQ_REG = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stat,
   input  logic [7:1]        wclr,
   input  logic [7:1]        set_vec,
   input  logic              busy,
   input  logic              ien,
   output logic [BYTE_W-1:0] stat,
   output logic              irq
);
   logic [7:1] flg_q;
   logic [7:1] clr;

   if (IRQ_REG > 1) begin : g_bad_irq
      $error("IRQ_REG must be 0 or 1");
   end

   assign clr = wr_stat ? wclr : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= (flg_q & ~clr) | set_vec;
   end

   assign stat = {flg_q, busy};

   if (IRQ_REG == 1) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= ien && (|flg_q);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = ien && (|flg_q);
      AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (flg_q == '0) |-> !irq);                                            // R11
   end

   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[2] && !(wr_stat && wclr[2])) |=> stat[2]);                       // R6
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec[1] && wr_stat && wclr[1]) |=> stat[1]);                       // R9
endmodule

// File: rtl/smbh_host_seq.sv
module smbh_host_seq
   import smbh_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned IRQ_REG = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq,
   output logic              op_valid,
   input  logic              op_ready,
   output logic [2:0]        op_proto,
   output logic [6:0]        op_addr,
   output logic              op_read,
   output logic [7:0]        op_cmd,
   output logic [15:0]       op_wdata,
   input  logic              op_done,
   input  logic              op_err,
   input  logic [15:0]       op_rdata
);
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_aw
      $error("ADDR_W too narrow for the register map");
   end

   logic                    wr_stat, wr_ctl, start, kill;
   logic [NBYTE-1:0]        wr_byte;
   logic [NBYTE*BYTE_W-1:0] bytes_q;
   logic [CTL_KEEP-1:0]     ctl_q;
   logic [BYTE_W-1:0]       stat;
   logic                    busy, set_done, set_fault, ld_lo, ld_hi;
   logic [7:1]              set_vec;

   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
   assign wr_ctl  = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));
   assign wr_byte = {reg_wr && (reg_addr == ADDR_W'(OFS_DHI)),
                     reg_wr && (reg_addr == ADDR_W'(OFS_DLO)),
                     reg_wr && (reg_addr == ADDR_W'(OFS_ADR)),
                     reg_wr && (reg_addr == ADDR_W'(OFS_CMD))};
   assign start   = wr_ctl && reg_wdata[CB_START];
   assign kill    = wr_ctl && reg_wdata[CB_KILL];

   smbh_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_byte (wr_byte),
      .wr_ctl  (wr_ctl),
      .wdata   (reg_wdata),
      .ld_lo   (ld_lo),
      .ld_hi   (ld_hi),
      .ld_val  (op_rdata),
      .bytes_q (bytes_q),
      .ctl_q   (ctl_q)
   );

   smbh_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .kill      (kill),
      .dev_err   (stat[2]),
      .proto_in  (reg_wdata[4:2]),
      .adr_in    (bytes_q[15:8]),
      .cmd_in    (bytes_q[7:0]),
      .wd_in     (bytes_q[31:16]),
      .op_valid  (op_valid),
      .op_ready  (op_ready),
      .op_proto  (op_proto),
      .op_addr   (op_addr),
      .op_read   (op_read),
      .op_cmd    (op_cmd),
      .op_wdata  (op_wdata),
      .op_done   (op_done),
      .op_err    (op_err),
      .busy      (busy),
      .set_done  (set_done),
      .set_fault (set_fault),
      .ld_lo     (ld_lo),
      .ld_hi     (ld_hi)
   );

   // bit 4 failed, bit 2 device fault, bit 1 done
   assign set_vec = {3'b000, kill, 1'b0, set_fault, set_done};

   smbh_status #(.IRQ_REG(IRQ_REG)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stat (wr_stat),
      .wclr    (reg_wdata[7:1]),
      .set_vec (set_vec),
      .busy    (busy),
      .ien     (ctl_q[CB_IEN]),
      .stat    (stat),
      .irq     (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == ADDR_W'(OFS_STAT)) reg_rdata = stat;
      else if (reg_addr == ADDR_W'(OFS_CTL))  reg_rdata = {3'b000, ctl_q};
      else if (reg_addr == ADDR_W'(OFS_CMD))  reg_rdata = bytes_q[7:0];
      else if (reg_addr == ADDR_W'(OFS_ADR))  reg_rdata = bytes_q[15:8];
      else if (reg_addr == ADDR_W'(OFS_DLO))  reg_rdata = bytes_q[23:16];
      else if (reg_addr == ADDR_W'(OFS_DHI))  reg_rdata = bytes_q[31:24];
   end

   AST_BUSY_SURVIVES_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_stat && !op_done && !kill) |=> stat[0]);                   // R9
   AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_valid && !kill && !op_ready) |=> $stable(op_cmd));         // R12
endmodule

// File: tb/tb_smbh_host_seq.sv
`timescale 1ns/1ps
module tb_smbh_host_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        irq, op_valid, op_read;
   logic        op_ready = 1'b0, op_done = 1'b0, op_err = 1'b0;
   logic [15:0] op_rdata = '0, op_wdata;
   logic [2:0]  op_proto;
   logic [6:0]  op_addr;
   logic [7:0]  op_cmd;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [7:0] m_cmd, m_adr, m_dlo, m_dhi;

   always #5 clk = ~clk;

   smbh_host_seq dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .op_valid(op_valid), .op_ready(op_ready), .op_proto(op_proto),
      .op_addr(op_addr), .op_read(op_read), .op_cmd(op_cmd),
      .op_wdata(op_wdata), .op_done(op_done), .op_err(op_err),
      .op_rdata(op_rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   function automatic bit loads_lo(input logic [2:0] p, input bit r);
      return (p == 3'd4) || (r && (p == 3'd1 || p == 3'd2 || p == 3'd3));
   endfunction

   function automatic bit loads_hi(input logic [2:0] p, input bit r);
      return (p == 3'd4) || (r && p == 3'd3);
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // one full transaction with random fields and response
   task automatic rand_txn(input bit force_err);
      logic [7:0] v;
      logic [2:0] p;
      bit ien, e;
      logic [15:0] r;
      p   = 3'($urandom % 5);
      ien = 1'($urandom);
      e   = force_err | (($urandom % 4) == 0);
      r   = 16'($urandom);
      m_cmd = 8'($urandom); m_adr = 8'($urandom);
      m_dlo = 8'($urandom); m_dhi = 8'($urandom);
      wr(4'h0, 8'hFE);
      wr(4'h3, m_cmd); wr(4'h4, m_adr); wr(4'h5, m_dlo); wr(4'h6, m_dhi);
      wr(4'h2, 8'h40 | {3'b000, p, 1'b0, ien});
      check("R3 op_valid", op_valid, 1);
      check("R3 op_proto", op_proto, p);
      check("R3 op_addr", op_addr, m_adr[7:1]);
      check("R3 op_read", op_read, m_adr[0]);
      check("R3 op_cmd", op_cmd, m_cmd);
      check("R3 op_wdata", op_wdata, {m_dhi, m_dlo});
      rd(4'h0, v); check("R4 busy during request", v, 8'h01);
      check("R11 busy alone no irq", irq, 0);
      repeat ($urandom % 3) @(negedge clk);
      check("R3 valid held", op_valid, 1);
      op_ready = 1'b1;
      @(negedge clk);
      op_ready = 1'b0;
      check("R3 valid drops after handshake", op_valid, 0);
      repeat ($urandom % 4) @(negedge clk);
      op_done = 1'b1; op_err = e; op_rdata = r;
      @(negedge clk);
      op_done = 1'b0; op_err = 1'b0;
      if (!e) begin
         if (loads_lo(p, m_adr[0])) m_dlo = r[7:0];
         if (loads_hi(p, m_adr[0])) m_dhi = r[15:8];
      end
      rd(4'h0, v);
      check(e ? "R6 fault status" : "R5 done status", v, e ? 8'h04 : 8'h02);
      check("R11 irq after completion", irq, ien);
      rd(4'h5, v); check(e ? "R6 data low kept" : "R5 data low", v, m_dlo);
      rd(4'h6, v); check(e ? "R6 data high kept" : "R5 data high", v, m_dhi);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), v); check("R1 reset read", v, 0);
      end
      check("R1 irq", irq, 0);
      check("R1 op_valid", op_valid, 0);

      // R2 readback
      wr(4'h3, 8'hA5); wr(4'h4, 8'h3C); wr(4'h5, 8'h81); wr(4'h6, 8'h7E);
      rd(4'h3, v); check("R2 command", v, 8'hA5);
      rd(4'h4, v); check("R2 address", v, 8'h3C);
      rd(4'h5, v); check("R2 data low", v, 8'h81);
      rd(4'h6, v); check("R2 data high", v, 8'h7E);
      wr(4'h2, 8'hBD);
      rd(4'h2, v); check("R2 control bits 4:0", v, 8'h1D);
      wr(4'h7, 8'h55); rd(4'h7, v); check("R2 unmapped 0x7", v, 0);
      wr(4'hD, 8'h02); rd(4'hD, v); check("R2 unmapped 0xD", v, 0);
      check("R2 no request", op_valid, 0);

      // R8 unsupported protocol, R11 irq gating, R9 clear
      wr(4'h2, 8'h54);
      check("R8 no request", op_valid, 0);
      rd(4'h0, v); check("R8 fault set", v, 8'h04);
      check("R11 irq disabled", irq, 0);
      wr(4'h2, 8'h01);
      check("R11 irq enabled", irq, 1);
      // R7 refusal while fault pending
      wr(4'h2, 8'h49);
      check("R7 no request", op_valid, 0);
      rd(4'h0, v); check("R7 busy stays 0", v, 8'h04);
      wr(4'h0, 8'hFF);
      rd(4'h0, v); check("R9 cleared", v, 0);
      check("R9 irq low after clear", irq, 0);

      // R9 busy survives W1C, R12 start while busy
      wr(4'h3, 8'h11);
      wr(4'h2, 8'h4C);              // word-data start
      check("R3 directed request", op_valid, 1);
      wr(4'h0, 8'hFF);
      rd(4'h0, v); check("R9 busy not cleared", v, 8'h01);
      wr(4'h3, 8'h22);
      wr(4'h2, 8'h44);              // byte start while busy
      check("R12 proto unchanged", op_proto, 3'd3);
      check("R12 cmd unchanged", op_cmd, 8'h11);
      check("R12 still valid", op_valid, 1);

      // R10 kill in request phase
      wr(4'h2, 8'h02);
      check("R10 valid withdrawn", op_valid, 0);
      rd(4'h0, v); check("R10 failed set, busy clear", v, 8'h10);
      op_done = 1'b1; @(negedge clk); op_done = 1'b0;
      rd(4'h0, v); check("R10 late completion ignored", v, 8'h10);

      // R10 kill during wait, then kill with start
      wr(4'h0, 8'hFF);
      wr(4'h2, 8'h40);
      op_ready = 1'b1; @(negedge clk); op_ready = 1'b0;
      wr(4'h2, 8'h02);
      rd(4'h0, v); check("R10 kill in wait", v, 8'h10);
      op_done = 1'b1; op_rdata = 16'hFFFF; @(negedge clk); op_done = 1'b0;
      rd(4'h0, v); check("R10 no done after kill", v, 8'h10);
      wr(4'h2, 8'h42);
      check("R10 kill beats start", op_valid, 0);

      // R6 directed error, then R7 refusal
      rand_txn(1'b1);
      wr(4'h2, 8'h40);
      check("R7 refused after error", op_valid, 0);

      for (int i = 0; i < 40; i++) rand_txn(1'b0);

      finished = 1'b1;
      finish_run();
   end
endmodule